// File: doc/BRIEF.md
# Flash Bus Interface Mode Controller

This block is the control front end of an asynchronous, SRAM-style flash bus. Four active-low pins (chip enable, output enable, write enable and reset) are sampled every cycle. The block decodes them into one of six bus cycle types: standby, read, output disable, write, reset and an illegal conflict. It drives the per-line enable of the data bus tristate and chooses what the data lines carry.

A read-mode register picks the source for reads: the storage array, the status register, the identifier space or the query table. The command interpreter next to the block changes this register with a one-cycle load request. A bus reset or power-on returns it to array reads. In identifier mode, an address whose bits above bit 0 are all zero returns built-in manufacturer and device codes. Any other identifier address passes the identifier input through.

A write cycle captures address and data on every cycle it lasts. When write enable or chip enable ends the cycle, the last captured pair goes to the command interpreter with a one-cycle strobe. A busy flag is set when an internal operation starts and stays set until that operation reports done. Deselecting the device does not clear it; only a bus reset does.

Top module: `flash_bus_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) and after any cycle sampled with `rp_n` low, `read_mode` is 0 (array) and `busy` is 0. Reset takes priority over `mode_wr`, `op_start` and `op_done`.
- R2: With `rp_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1 (read), `cyc` is 1 and `dq_oe` enables the active lanes in the same cycle.
- R3: With `rp_n`=1, `ce_n`=0, `we_n`=1 and `oe_n`=1 (output disable), `cyc` is 2, and `dq_oe` and `dq_out` are all zero.
- R4: With `rp_n`=1 and `ce_n`=1 (standby), `cyc` is 0 and `dq_oe`/`dq_out` are zero, whatever `oe_n` and `we_n` are.
- R5: With `rp_n`=0, `cyc` is 4 and `dq_oe`/`dq_out` are zero, whatever the other pins are.
- R6: With `rp_n`=1, `ce_n`=0, `we_n`=0 and `oe_n`=1 (write), `cyc` is 3. On the first cycle that is no longer a write, with `rp_n` still 1, `cmd_stb` is high for exactly one cycle. It is seen in the cycle after that change, and `cmd_addr`/`cmd_data` hold the address and data of the last write cycle.
- R7: A cycle with `mode_wr`=1 and `rp_n`=1 loads `mode_sel` into `read_mode`. Encoding: 0 array (`array_data`), 1 identifier, 2 status (`status_data`), 3 query (`query_data`).
- R8: In identifier mode, `addr[AW-1:1]`=0 returns `MFR_CODE` when `addr[0]`=0 and `DEV_CODE` when `addr[0]`=1. Any other address returns `ident_data`.
- R9: `busy` goes to 1 in the cycle after `op_start`. It stays 1 through standby and through any other bus cycle until a cycle with `op_done`, after which it is 0.
- R10: With `byte_mode`=1, a read enables only `dq_oe[7:0]` and `dq_out[15:8]` is 0. With `byte_mode`=0, all 16 lanes are enabled.
- R11: With `rp_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=0 (conflict), `cyc` is 5, nothing is driven and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rp_n | input | 1 | Bus reset, active low |
| byte_mode | input | 1 | 1 selects the 8-line bus |
| addr | input | AW | Bus address |
| dq_in | input | DW | Data lines, input side |
| dq_out | output | DW | Data lines, output side |
| dq_oe | output | DW | Per-line tristate enable |
| cyc | output | 3 | Decoded bus cycle type |
| mode_wr | input | 1 | Read-mode load request |
| mode_sel | input | 2 | Read mode to load |
| read_mode | output | 2 | Active read mode |
| array_data | input | DW | Array read data |
| status_data | input | DW | Status register value |
| ident_data | input | DW | Identifier space data |
| query_data | input | DW | Query table data |
| op_start | input | 1 | Internal operation starts |
| op_done | input | 1 | Internal operation finished |
| busy | output | 1 | Internal operation in progress |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_addr | output | AW | Captured write address |
| cmd_data | output | DW | Captured write data |

## Verification
The assertions assume that the bus pins are already synchronous to `clk` and that `op_start` and `op_done` come from an engine that does not raise both in the same cycle. The bench changes every input only on the falling clock edge. It draws the pins from $urandom without restriction, so all sixteen pin combinations occur, conflicts included. `op_start` and `op_done` are drawn so that they are never high together, and `por_n` stays high after the first reset. Directed sequences add a write ended by chip enable, busy held across a long standby, and identifier reads at both code addresses.

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter logic [DW-1:0] MFR_CODE = 16'h00A5,
  parameter logic [DW-1:0] DEV_CODE = 16'h5A3C
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          byte_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic [2:0]    cyc,
  input  logic          mode_wr,
  input  logic [1:0]    mode_sel,
  output logic [1:0]    read_mode,
  input  logic [DW-1:0] array_data,
  input  logic [DW-1:0] status_data,
  input  logic [DW-1:0] ident_data,
  input  logic [DW-1:0] query_data,
  input  logic          op_start,
  input  logic          op_done,
  output logic          busy,
  output logic          cmd_stb,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  localparam logic [2:0] C_STBY = 3'd0, C_READ = 3'd1, C_ODIS = 3'd2,
                         C_WRITE = 3'd3, C_RST = 3'd4, C_CONF = 3'd5;
  localparam logic [DW-1:0] BYTE_LANES = {{(DW-8){1'b0}}, 8'hFF};

  logic          rd_act, wr_act, wr_q, id_hit;
  logic [DW-1:0] lanes, src;

  always_comb begin
    if (!rp_n)              cyc = C_RST;
    else if (ce_n)          cyc = C_STBY;
    else if (!we_n && oe_n) cyc = C_WRITE;
    else if (!we_n)         cyc = C_CONF;
    else if (oe_n)          cyc = C_ODIS;
    else                    cyc = C_READ;
  end

  assign rd_act = (cyc == C_READ);
  assign wr_act = (cyc == C_WRITE);
  assign lanes  = byte_mode ? BYTE_LANES : '1;
  assign id_hit = (addr[AW-1:1] == '0);

  always_comb begin
    unique case (read_mode)
      2'd0: src = array_data;
      2'd1: src = id_hit ? (addr[0] ? DEV_CODE : MFR_CODE) : ident_data;
      2'd2: src = status_data;
      default: src = query_data;
    endcase
  end

  assign dq_oe  = rd_act ? lanes : '0;
  assign dq_out = rd_act ? (src & lanes) : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      read_mode <= 2'd0;
      busy      <= 1'b0;
      wr_q      <= 1'b0;
      cmd_stb   <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      wr_q    <= wr_act;
      cmd_stb <= wr_q && !wr_act && rp_n;
      if (wr_act) begin
        cmd_addr <= addr;
        cmd_data <= dq_in;
      end
      if (!rp_n) begin
        read_mode <= 2'd0;
        busy      <= 1'b0;
      end else begin
        if (mode_wr) read_mode <= mode_sel;
        if (op_start)     busy <= 1'b1;
        else if (op_done) busy <= 1'b0;
      end
    end
  end
endmodule

module flash_bus_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          por_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          rp_n,
  input logic          byte_mode,
  input logic          op_done,
  input logic [DW-1:0] dq_oe,
  input logic [2:0]    cyc,
  input logic [1:0]    read_mode,
  input logic          busy,
  input logic          cmd_stb
);
  // R5
  reset_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rp_n |-> (dq_oe == '0 && cyc == 3'd4));
  // R4
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rp_n && ce_n) |-> (dq_oe == '0 && cyc == 3'd0));
  // R3
  oe_high_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
    oe_n |-> dq_oe == '0);
  // R10
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!por_n)
    byte_mode |-> dq_oe[DW-1:8] == '0);
  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rp_n |=> (read_mode == 2'd0 && !busy));
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    cmd_stb |=> !cmd_stb);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (busy && rp_n && !op_done) |=> busy);
  // R11
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rp_n && !ce_n && !oe_n && !we_n) |-> (dq_oe == '0 && cyc == 3'd5));
endmodule

bind flash_bus_ctrl flash_bus_chk #(.DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .rp_n(rp_n), .byte_mode(byte_mode), .op_done(op_done), .dq_oe(dq_oe),
  .cyc(cyc), .read_mode(read_mode), .busy(busy), .cmd_stb(cmd_stb)
);

// File: tb/sim_flash_bus_ctrl.sv
module sim_flash_bus_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [DW-1:0] MFR = 16'h00A5;
  localparam logic [DW-1:0] DEV = 16'h5A3C;

  logic clk = 0, por_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, rp_n = 1, byte_mode = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, arr = '0, sts = '0, idn = '0, qry = '0;
  logic mode_wr = 0, op_start = 0, op_done = 0;
  logic [1:0] mode_sel = '0;
  logic [DW-1:0] dq_out, dq_oe, cmd_data;
  logic [AW-1:0] cmd_addr;
  logic [2:0] cyc;
  logic [1:0] read_mode;
  logic busy, cmd_stb;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_mode = 0;
  logic m_busy = 0, m_wrq = 0, m_stb = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always #(PERIOD/2) clk = ~clk;

  flash_bus_ctrl #(.AW(AW), .DW(DW), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rp_n(rp_n), .byte_mode(byte_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .cyc(cyc), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .read_mode(read_mode), .array_data(arr),
    .status_data(sts), .ident_data(idn), .query_data(qry),
    .op_start(op_start), .op_done(op_done), .busy(busy), .cmd_stb(cmd_stb),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  function automatic logic [2:0] f_cyc(logic c, logic o, logic w, logic r);
    if (!r) return 3'd4;
    if (c) return 3'd0;
    if (!w && o) return 3'd3;
    if (!w) return 3'd5;
    if (o) return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic [DW-1:0] f_src(logic [1:0] m);
    case (m)
      2'd0: return arr;
      2'd1: return (addr[AW-1:1] == '0) ? (addr[0] ? DEV : MFR) : idn;
      2'd2: return sts;
      default: return qry;
    endcase
  endfunction

  function automatic string f_tag(logic [2:0] c);
    case (c)
      3'd0: return "R4 standby";
      3'd1: return "R2 read";
      3'd2: return "R3 output-disable";
      3'd3: return "R6 write";
      3'd4: return "R5 reset";
      default: return "R11 conflict";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(logic c, logic o, logic w, logic r, logic b,
                      logic [AW-1:0] a, logic mw, logic [1:0] ms,
                      logic os, logic od);
    logic [2:0] ec;
    logic [DW-1:0] lanes;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; rp_n = r; byte_mode = b; addr = a;
    mode_wr = mw; mode_sel = ms; op_start = os; op_done = od;
    dq_in = DW'($urandom); arr = DW'($urandom); sts = DW'($urandom);
    idn = DW'($urandom); qry = DW'($urandom);
    #1;
    ec = f_cyc(c, o, w, r);
    lanes = b ? 16'h00FF : 16'hFFFF;
    chk({f_tag(ec), " cyc"}, 32'(cyc), 32'(ec));
    chk({f_tag(ec), (b ? " R10" : ""), " dq_oe"}, 32'(dq_oe),
        32'((ec == 3'd1) ? lanes : '0));
    chk({f_tag(ec), (m_mode == 1 ? " R8" : " R7"), " dq_out"}, 32'(dq_out),
        32'((ec == 3'd1) ? (f_src(m_mode) & lanes) : '0));
    @(posedge clk);
    m_stb = m_wrq && (ec != 3'd3) && r;
    m_wrq = (ec == 3'd3);
    if (ec == 3'd3) begin m_addr = a; m_data = dq_in; end
    if (!r) begin m_mode = 0; m_busy = 0; end
    else begin
      if (mw) m_mode = ms;
      if (os) m_busy = 1; else if (od) m_busy = 0;
    end
    #1;
    chk(r ? "R7 read_mode" : "R1 read_mode", 32'(read_mode), 32'(m_mode));
    chk(r ? "R9 busy" : "R1 busy", 32'(busy), 32'(m_busy));
    chk("R6 cmd_stb", 32'(cmd_stb), 32'(m_stb));
    if (m_stb) begin
      chk("R6 cmd_addr", 32'(cmd_addr), 32'(m_addr));
      chk("R6 cmd_data", 32'(cmd_data), 32'(m_data));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 power-on state
    chk("R1 por read_mode", 32'(read_mode), 0);
    chk("R1 por busy", 32'(busy), 0);
    chk("R1 por cmd_stb", 32'(cmd_stb), 0);
    @(negedge clk); por_n = 1;

    // R6 write ended by chip enable
    tick(0, 1, 0, 1, 0, 21'h00123, 0, 0, 0, 0);
    tick(0, 1, 0, 1, 0, 21'h00456, 0, 0, 0, 0);
    tick(1, 1, 0, 1, 0, 21'h00000, 0, 0, 0, 0);
    tick(1, 1, 1, 1, 0, 21'h00000, 0, 0, 0, 0);
    // R9 busy across long standby
    tick(1, 1, 1, 1, 0, 21'h0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) tick(1, 0, 1, 1, 0, 21'h0, 0, 0, 0, 0);
    tick(1, 1, 1, 1, 0, 21'h0, 0, 0, 0, 1);
    // R8 identifier codes, word and byte
    tick(1, 1, 1, 1, 0, 21'h0, 1, 2'd1, 0, 0);
    tick(0, 0, 1, 1, 0, 21'h00000, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 0, 21'h00001, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 1, 21'h00001, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 0, 21'h00002, 0, 0, 0, 0);
    // R1 bus reset beats mode load and op start
    tick(0, 0, 1, 0, 0, 21'h0, 1, 2'd3, 1, 0);
    tick(0, 0, 1, 1, 0, 21'h0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] p;
      logic [AW-1:0] a;
      logic [1:0] ev;
      p = 4'($urandom);
      a = ($urandom % 4 == 0) ? AW'($urandom % 2) : AW'($urandom);
      ev = 2'($urandom % 8);
      tick(p[0], p[1], p[2], (p[3] || ($urandom % 4 != 0)), 1'($urandom),
           a, ($urandom % 6 == 0), 2'($urandom), ev == 2'd1, ev == 2'd2);
    end
    finish_run();
  end
endmodule